// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

The monitor watches two processor mask bits, the ordinary interrupt mask and the non-maskable-interrupt mask, and measures how many clock cycles each bit stays set. A free-running cycle counter supplies the time base. Each mask has its own channel. A channel records the counter value when a masked stretch begins. When the stretch ends, it turns the elapsed count into a duration and folds that duration into three results: the shortest stretch, the longest stretch and the most recent stretch.

Each channel also shows the length of the stretch in progress. A per-channel read-select input marks a read of the statistics. A read made during a stretch lets the elapsed length raise the longest-stretch result, so a stretch that has not ended yet still counts toward the maximum. The shortest-stretch register starts at an all-ones sentinel. While it still holds that value, the reported minimum falls back to the maximum.

The cycle counter saturates at all ones and does not wrap. Once it has saturated, the elapsed length of any stretch stops growing.

Top module: `mask_hold_monitor`

## Requirements
- R1: After reset, every reported value is 0 on both channels: minimum, maximum, last and in-progress length.
- R2: A stretch begins on the first clock edge that samples the mask bit at 1 while no stretch is active. After j edges that sample the bit at 1, the in-progress output reads j. It reads 0 when no stretch is active.
- R3: The first edge that samples the mask at 0 during a stretch ends it. The last output then equals the number of edges that sampled the mask at 1.
- R4: An ending stretch replaces the minimum only if its duration is smaller, and replaces the maximum only if its duration is larger. For example, the durations 5, 3 and 8 leave minimum 3, maximum 8 and last 8.
- R5: The two channels are independent. Channel I follows `imask_bit`, `rd_sel[0]` and the `i_*` outputs. Channel X follows `xmask_bit`, `rd_sel[1]` and the `x_*` outputs. Activity on one channel never changes the other channel's outputs.
- R6: While the internal minimum still holds the all-ones sentinel, the reported minimum equals the reported maximum.
- R7: An edge that samples a channel's `rd_sel` bit at 1 during an active stretch sets that channel's maximum to the elapsed length if the elapsed length is larger. A read with no active stretch, or with a smaller elapsed length, changes nothing.
- R8: The cycle counter stops at all ones. After it saturates, the in-progress length holds steady, and a stretch that starts afterwards ends with duration 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| imask_bit | input | 1 | Interrupt mask bit (channel I) |
| xmask_bit | input | 1 | Non-maskable-interrupt mask bit (channel X) |
| rd_sel | input | 2 | Read-select per channel; bit 0 is channel I, bit 1 is channel X |
| i_min | output | W | Channel I shortest stretch, with the fallback rule applied |
| i_max | output | W | Channel I longest stretch |
| i_last | output | W | Channel I most recent completed stretch |
| i_cur | output | W | Channel I in-progress length |
| x_min | output | W | Channel X shortest stretch, with the fallback rule applied |
| x_max | output | W | Channel X longest stretch |
| x_last | output | W | Channel X most recent completed stretch |
| x_cur | output | W | Channel X in-progress length |

## Verification
The hardest state to reach from the ports is counter saturation. With the default 32-bit width it would take billions of cycles. The bench therefore builds the block at 16 bits, resets it a second time and holds a stretch open across the point where the counter tops out. It then checks that the in-progress length freezes, that the ending stretch reports the frozen value, and that a later stretch measures 0. The sentinel fallback is reached by issuing a read during the first stretch, before any stretch has completed.

// File: rtl/msm_pkg.sv
package msm_pkg;
  localparam int NCH  = 2;
  localparam int CH_I = 0;
  localparam int CH_X = 1;
endpackage

// File: rtl/msm_rst_sync.sv
module msm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/msm_cycle_ctr.sv
module msm_cycle_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic         cnt_en;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_en = (cnt != TOP);
    cnt_d  = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  // R8
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= $past(cnt));
endmodule

// File: rtl/msm_channel.sv
module msm_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         mask,
  input  logic         rd,
  output logic [W-1:0] min_rep,
  output logic [W-1:0] max_o,
  output logic [W-1:0] last_o,
  output logic [W-1:0] cur_o
);
  localparam logic [W-1:0] SENT = {W{1'b1}};

  logic         active_q, active_d;
  logic [W-1:0] start_q, start_d;
  logic [W-1:0] min_q, min_d;
  logic [W-1:0] max_q, max_d;
  logic [W-1:0] last_q, last_d;
  logic [W-1:0] elapsed;
  logic         begin_ev, end_ev, rd_ev;

  always_comb begin
    elapsed  = active_q ? (cnt - start_q) : '0;
    begin_ev = mask & ~active_q;
    end_ev   = ~mask & active_q;
    rd_ev    = rd & active_q & mask;
    active_d = active_q;
    start_d  = start_q;
    min_d    = min_q;
    max_d    = max_q;
    last_d   = last_q;
    if (begin_ev) begin
      active_d = 1'b1;
      start_d  = cnt;
    end
    if (end_ev) begin
      active_d = 1'b0;
      last_d   = elapsed;
      if (elapsed < min_q) min_d = elapsed;
      if (elapsed > max_q) max_d = elapsed;
    end else if (rd_ev && (elapsed > max_q)) begin
      max_d = elapsed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      start_q  <= '0;
      min_q    <= SENT;
      max_q    <= '0;
      last_q   <= '0;
    end else begin
      active_q <= active_d;
      if (begin_ev) start_q <= start_d;
      if (end_ev) begin
        last_q <= last_d;
        min_q  <= min_d;
      end
      if (end_ev || rd_ev) max_q <= max_d;
    end
  end

  assign min_rep = (min_q == SENT) ? max_q : min_q;
  assign max_o   = max_q;
  assign last_o  = last_q;
  assign cur_o   = elapsed;

  // R2
  cur_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && mask && cnt != SENT) |=> (cur_o == $past(cur_o) + 1'b1));
  // R3
  last_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !mask) |=> (last_o == $past(cur_o) && cur_o == '0));
  // R4
  max_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (max_o >= last_o) && (min_rep <= max_o));
  // R7
  read_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && active_q && mask) |=> (max_o >= $past(cur_o)));
endmodule

// File: rtl/mask_hold_monitor.sv
module mask_hold_monitor #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         imask_bit,
  input  logic         xmask_bit,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] i_min,
  output logic [W-1:0] i_max,
  output logic [W-1:0] i_last,
  output logic [W-1:0] i_cur,
  output logic [W-1:0] x_min,
  output logic [W-1:0] x_max,
  output logic [W-1:0] x_last,
  output logic [W-1:0] x_cur
);
  import msm_pkg::*;

  logic               rst_sync_n;
  logic [W-1:0]       cnt;
  logic [NCH-1:0]     mask_v;
  logic [W-1:0]       min_a  [NCH];
  logic [W-1:0]       max_a  [NCH];
  logic [W-1:0]       last_a [NCH];
  logic [W-1:0]       cur_a  [NCH];

  assign mask_v[CH_I] = imask_bit;
  assign mask_v[CH_X] = xmask_bit;

  msm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  msm_cycle_ctr #(.W(W)) u_ctr (.clk(clk), .rst_n(rst_sync_n), .cnt(cnt));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    msm_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .cnt(cnt),
      .mask(mask_v[c]), .rd(rd_sel[c]),
      .min_rep(min_a[c]), .max_o(max_a[c]),
      .last_o(last_a[c]), .cur_o(cur_a[c])
    );
  end

  assign i_min  = min_a[CH_I];
  assign i_max  = max_a[CH_I];
  assign i_last = last_a[CH_I];
  assign i_cur  = cur_a[CH_I];
  assign x_min  = min_a[CH_X];
  assign x_max  = max_a[CH_X];
  assign x_last = last_a[CH_X];
  assign x_cur  = cur_a[CH_X];
endmodule

// File: tb/test_mask_hold_monitor.sv
module test_mask_hold_monitor;
  localparam int W = 16;
  localparam logic [W-1:0] SENT = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n;
  logic imask_bit, xmask_bit;
  logic [1:0] rd_sel;
  logic [W-1:0] i_min, i_max, i_last, i_cur, x_min, x_max, x_last, x_cur;

  always #4 clk = ~clk;

  mask_hold_monitor #(.W(W)) i_mask_hold_monitor (
    .clk(clk), .rst_n(rst_n), .imask_bit(imask_bit), .xmask_bit(xmask_bit),
    .rd_sel(rd_sel), .i_min(i_min), .i_max(i_max), .i_last(i_last), .i_cur(i_cur),
    .x_min(x_min), .x_max(x_max), .x_last(x_last), .x_cur(x_cur));

  typedef struct {
    int          due;
    int          ch;
    int          kind;
    logic [W-1:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [W-1:0] m_min [2];
  logic [W-1:0] m_max [2];
  logic [W-1:0] m_last[2];
  logic [W-1:0] held;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] obs(int ch, int kind);
    case (kind)
      0: return ch == 0 ? i_min  : x_min;
      1: return ch == 0 ? i_max  : x_max;
      2: return ch == 0 ? i_last : x_last;
      default: return ch == 0 ? i_cur : x_cur;
    endcase
  endfunction

  task automatic expect_v(int ch, int kind, logic [W-1:0] v, string req);
    item_t it;
    it.due = cyc + 1; it.ch = ch; it.kind = kind; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  function automatic logic [W-1:0] rep_min(int ch);
    return (m_min[ch] == SENT) ? m_max[ch] : m_min[ch];
  endfunction

  task automatic expect_stats(int ch, string req);
    expect_v(ch, 0, rep_min(ch), req);
    expect_v(ch, 1, m_max[ch], req);
    expect_v(ch, 2, m_last[ch], req);
  endtask

  task automatic set_mask(int ch, logic v);
    if (ch == 0) imask_bit = v; else xmask_bit = v;
  endtask

  // Monitor: compares each queued item at its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [W-1:0] a;
      it = q.pop_front();
      a = obs(it.ch, it.kind);
      total++;
      if (a !== it.exp) begin
        bad++;
        $display("FAIL %s ch=%0d kind=%0d actual=%0d expected=%0d",
                 it.req, it.ch, it.kind, a, it.exp);
      end
    end
  end

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_min[c] = SENT; m_max[c] = '0; m_last[c] = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; imask_bit = 0; xmask_bit = 0; rd_sel = 2'b00;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_stretch(int ch, int len);
    logic [W-1:0] d;
    d = len[W-1:0];
    set_mask(ch, 0);
    m_last[ch] = d;
    if (d < m_min[ch]) m_min[ch] = d;
    if (d > m_max[ch]) m_max[ch] = d;
    expect_stats(ch, "R3/R4");
    expect_v(ch, 3, '0, "R2 idle cur");
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stretch(int ch, int len);
    set_mask(ch, 1);
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      if (j == 2) expect_v(ch, 3, 3, "R2 cur=3");
    end
    end_stretch(ch, len);
  endtask

  initial begin
    do_reset();
    // R1
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++) expect_v(c, k, '0, "R1 reset");
    @(negedge clk); @(negedge clk);

    // R6 / R7: read during first X stretch, before any completion
    set_mask(1, 1);
    repeat (10) @(negedge clk);
    rd_sel = 2'b10;
    m_max[1] = 10;
    expect_v(1, 1, 10, "R7 read raises max");
    expect_v(1, 0, 10, "R6 sentinel fallback");
    @(negedge clk);
    rd_sel = 2'b00;
    @(negedge clk);
    end_stretch(1, 12);

    // R2 R3 R4 on channel I
    stretch(0, 5);
    stretch(0, 3);
    stretch(0, 8);
    // R5: X untouched by I activity
    expect_stats(1, "R5 X unchanged");

    // R7: read with no stretch active has no effect
    rd_sel = 2'b01;
    expect_stats(0, "R7 idle read");
    @(negedge clk);
    rd_sel = 2'b00;
    @(negedge clk);

    // R7: read with smaller elapsed leaves max
    set_mask(1, 1);
    @(negedge clk); @(negedge clk);
    rd_sel = 2'b10;
    expect_v(1, 1, 12, "R7 small read");
    @(negedge clk);
    rd_sel = 2'b00;
    end_stretch(1, 3);
    // R5: I untouched by X activity
    expect_stats(0, "R5 I unchanged");
    @(negedge clk);

    // R8: saturation
    do_reset();
    repeat (65400) @(negedge clk);
    set_mask(0, 1);
    repeat (300) @(negedge clk);
    held = i_cur;
    @(negedge clk);
    total++;
    if (i_cur !== held || held == '0) begin
      bad++;
      $display("FAIL R8 cur frozen actual=%0d expected=%0d", i_cur, held);
    end
    set_mask(0, 0);
    expect_v(0, 2, held, "R8 last at saturation");
    @(negedge clk); @(negedge clk);
    set_mask(0, 1);
    repeat (5) @(negedge clk);
    set_mask(0, 0);
    expect_v(0, 2, '0, "R8 post-sat last");
    expect_v(0, 0, '0, "R8 post-sat min");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (!done && cyc < 200000) @(negedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule